// File: doc/BRIEF.md
# Clock-Enable Configuration Slave for a Ten-Output Fanout Buffer

This block sits beside a ten-way clock fanout buffer and decides which buffered copies of the input clock reach their pins. A host reaches it over a two-wire serial bus with open-drain data. SCL and SDA are sampled by a system clock that runs much faster than SCL. The host writes enable bytes in block form. After the device address it sends a command byte and a length byte, and the block acknowledges both without storing them. The data bytes that follow fill the enable registers from the lowest one upward until the host sends a stop.

A block read returns a length of seven, then seven register bytes. Only the lowest three register bytes exist, and the four bytes above them read as all ones. Each enable bit either lets its output follow the buffer input clock or parks the output low. An enable change is retimed into the buffer clock domain and applied only during the low phase of that clock, so an output never starts or stops with a shortened pulse. A separate drive-enable input turns off the pad drive of every output at once, whatever the registers hold.

Top module: `clkfan_cfg_slave`

## Requirements
- R1: The block acknowledges the address byte D2h (write) and D3h (read). For any other address it leaves SDA released and ignores the rest of the transfer. It changes its SDA pull only while SCL is low.
- R2: In a write, the first two bytes after the address are acknowledged and are never stored in any register.
- R3: In a write, data bytes land in register byte 0, then 1, then 2, in that order. Every data byte is acknowledged.
- R4: A stop after any complete byte ends loading and returns the slave to idle. Bytes already received stay latched, and registers not reached keep their earlier values.
- R5: A read sends the value 7 first, then register bytes 0 to 6 in order, MSB first. Bytes 3 to 6 read FFh.
- R6: An enable bit of 1 makes its output follow the buffer input clock. A bit of 0 holds the output low.
- R7: Outputs 3..0 are enabled by bits 3..0 of byte 0, outputs 9..8 by bits 7..6 of byte 1, and outputs 7..4 by bits 7..4 of byte 2. Every other bit of these bytes is stored and read back but gates nothing.
- R8: After reset, every register bit is 1, all ten outputs run, and a read returns FFh for each byte.
- R9: With `drive_en` low, all ten `fan_drive` bits are 0 (pads high impedance). With `drive_en` high they are all 1. The register contents are untouched either way.
- R10: An enable change reaches an output only while the buffer clock is low. Every high pulse on an output lasts a full high phase of the buffer clock.
- R11: Write data bytes beyond register byte 2 are acknowledged and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull | output | 1 | 1 pulls the data line low; 0 releases it |
| buf_clk | input | 1 | Buffer input clock to be fanned out |
| drive_en | input | 1 | 1 drives the outputs; 0 sets them to high impedance |
| fan_clk | output | 10 | Gated copies of `buf_clk` |
| fan_drive | output | 10 | Per-output pad drive enable |

## Verification
A corrupted register byte or enable bit shows at the pins within two falling edges of the buffer clock after the stop: an output runs when it should be parked low, or the reverse. A later block read reports the same bad value on SDA. A wrong byte index or bit counter in the serial engine shows within one byte time, as a missing or extra acknowledge or as data landing in the wrong register byte. A glitch in the retiming path shows as a short high pulse on an output, and a pulse-width monitor on all ten pins catches it at once.

// File: rtl/cfgbuf_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the clock-enable configuration slave.
// Assumes a fixed ten-output buffer and three implemented enable bytes.
package cfgbuf_pkg;
    localparam logic [6:0] BUS_ADDR7 = 7'h69;   // D2h write / D3h read
    localparam int NUM_OUT   = 10;
    localparam int REG_BYTES = 3;
    localparam int HDR_BYTES = 2;               // command + length, discarded
    localparam int RD_COUNT  = 7;               // length reported on read
    localparam int IDX_W     = 4;               // byte index width (saturating)

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK
    } eng_state_t;
endpackage

// File: rtl/tw_line_sampler.sv
`timescale 1ns/1ps
// Module: tw_line_sampler
// Brings SCL and SDA into the system clock domain and flags SCL edges plus
// start and stop conditions. Assumes the system clock is fast enough to see
// every SCL phase for several cycles.
module tw_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_prev;
    logic                   sda_prev;

    // Synchronizer chains for both lines; idle bus level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
            scl_prev <= scl_sync[SYNC_STAGES-1];
            sda_prev <= sda_sync[SYNC_STAGES-1];
        end
    end

    // Edge and condition decode from current and previous samples.
    always_comb begin
        scl_lvl   = scl_sync[SYNC_STAGES-1];
        sda_lvl   = sda_sync[SYNC_STAGES-1];
        scl_rise  = scl_lvl && !scl_prev;
        scl_fall  = !scl_lvl && scl_prev;
        bus_start = scl_lvl && scl_prev && sda_prev && !sda_lvl;
        bus_stop  = scl_lvl && scl_prev && !sda_prev && sda_lvl;
    end
endmodule

// File: rtl/tw_block_engine.sv
`timescale 1ns/1ps
// Module: tw_block_engine
// Byte-level slave state machine: address match, acknowledge, block-write
// loading (header bytes skipped) and block-read shifting with a leading length
// byte. Assumes SCL is never stretched and the host obeys SDA setup/hold.
module tw_block_engine
    import cfgbuf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = BUS_ADDR7,
    parameter int REGS   = REG_BYTES,
    parameter int HDR    = HDR_BYTES,
    parameter int LENGTH = RD_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_lvl,
    input  logic             sda_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             bus_start,
    input  logic             bus_stop,
    output logic             sda_pull,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [7:0]       rd_data
);
    localparam logic [IDX_W-1:0] HDR_L = IDX_W'(HDR);
    localparam logic [IDX_W-1:0] REG_L = IDX_W'(REGS);
    localparam logic [IDX_W-1:0] ONE_L = IDX_W'(1);
    localparam logic [7:0]       LEN_B = 8'(LENGTH);

    eng_state_t       state;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg;
    logic             addr_phase;
    logic             rd_mode;
    logic             host_ack;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_next;
    logic [7:0]       tx_byte;
    logic             wr_ok;

    // Read source, saturating index step and write-range decode.
    always_comb begin
        rd_idx   = idx - ONE_L;
        tx_byte  = (idx == '0) ? LEN_B : rd_data;
        idx_next = (idx == '1) ? idx : idx + ONE_L;
        wr_ok    = (idx >= HDR_L) && ((idx - HDR_L) < REG_L);
    end

    // Serial byte engine: receive, acknowledge, transmit, host-ack check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            addr_phase <= 1'b0;
            rd_mode    <= 1'b0;
            host_ack   <= 1'b0;
            idx        <= '0;
            sda_pull   <= 1'b0;
            wr_en      <= 1'b0;
            wr_idx     <= '0;
            wr_data    <= '0;
        end else begin
            wr_en <= 1'b0;
            if (bus_start) begin
                state      <= ST_RX;
                bit_cnt    <= '0;
                addr_phase <= 1'b1;
                rd_mode    <= 1'b0;
                idx        <= '0;
                sda_pull   <= 1'b0;
            end else if (bus_stop) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise && bit_cnt < 4'd8) begin
                            shreg   <= {shreg[6:0], sda_lvl};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            if (addr_phase) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    addr_phase <= 1'b0;
                                    rd_mode    <= shreg[0];
                                    sda_pull   <= 1'b1;
                                    state      <= ST_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                wr_en    <= wr_ok;
                                wr_idx   <= idx - HDR_L;
                                wr_data  <= shreg;
                                idx      <= idx_next;
                                sda_pull <= 1'b1;
                                state    <= ST_ACK;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rd_mode) begin
                                shreg    <= tx_byte;
                                sda_pull <= !tx_byte[7];
                                idx      <= idx_next;
                                state    <= ST_TX;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                sda_pull <= 1'b0;
                                state    <= ST_RACK;
                            end else begin
                                shreg    <= {shreg[6:0], 1'b0};
                                sda_pull <= !shreg[6];
                                bit_cnt  <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            host_ack <= !sda_lvl;
                        end else if (scl_fall) begin
                            if (host_ack) begin
                                shreg    <= tx_byte;
                                sda_pull <= !tx_byte[7];
                                idx      <= idx_next;
                                bit_cnt  <= '0;
                                state    <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_pull <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R1: the slave only starts pulling SDA while SCL is low.
    a_r1_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_lvl);

    // R4: a stop always returns to idle with SDA released.
    a_r4_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (state == ST_IDLE && !sda_pull));

    // R5: the first byte loaded for transmit is the length value.
    a_r5_length_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK && scl_fall && rd_mode && idx == '0 && !bus_start && !bus_stop)
        |=> (shreg == LEN_B));
endmodule

// File: rtl/cfg_reg_bank.sv
`timescale 1ns/1ps
// Module: cfg_reg_bank
// Holds the implemented enable bytes, all bits reset to one. Reads of an index
// beyond the implemented bytes return all ones. Assumes one write per cycle.
module cfg_reg_bank
    import cfgbuf_pkg::*;
#(
    parameter int REGS = REG_BYTES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [7:0]         rd_data,
    output logic [REGS*8-1:0]  cfg_flat
);
    logic [7:0] regs [REGS];

    // One register byte per implemented index.
    for (genvar g = 0; g < REGS; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= 8'hFF;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                regs[g] <= wr_data;
            end
        end
        assign cfg_flat[g*8 +: 8] = regs[g];
    end

    // Read mux with all-ones fill for unimplemented indices.
    always_comb begin
        rd_data = 8'hFF;
        for (int k = 0; k < REGS; k++) begin
            if (rd_idx == IDX_W'(k)) rd_data = regs[k];
        end
    end

    // R3/R11: the engine never addresses a byte that does not exist.
    a_r11_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDX_W'(REGS)));
endmodule

// File: rtl/clk_gate_lane.sv
`timescale 1ns/1ps
// Module: clk_gate_lane
// Retimes one enable into the buffer clock domain on falling edges and gates
// the clock with it, so the gate only moves while buf_clk is low. Assumes the
// system clock period is shorter than each buffer clock phase (for the check).
module clk_gate_lane #(
    parameter int SYNC_STAGES = 2
) (
    input  logic sys_clk,
    input  logic rst_n,
    input  logic buf_clk,
    input  logic en_req,
    output logic gated
);
    logic [SYNC_STAGES-1:0] en_sync;
    logic                   buf_seen;

    // Falling-edge synchronizer; reset value keeps the output running.
    always_ff @(negedge buf_clk) begin
        if (!rst_n) en_sync <= '1;
        else        en_sync <= {en_sync[SYNC_STAGES-2:0], en_req};
    end

    assign gated = buf_clk & en_sync[SYNC_STAGES-1];

    // Previous buffer clock level as seen by the system clock (check only).
    always_ff @(posedge sys_clk) begin
        if (!rst_n) buf_seen <= 1'b0;
        else        buf_seen <= buf_clk;
    end

    // R10: the applied enable never moves during a high phase of buf_clk.
    a_r10_gate_quiet_high: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (buf_seen && buf_clk) |-> $stable(en_sync[SYNC_STAGES-1]));
endmodule

// File: rtl/clkfan_cfg_slave.sv
`timescale 1ns/1ps
// Module: clkfan_cfg_slave (top)
// Serial enable-register slave for a ten-output clock fanout buffer: line
// sampling, byte engine, register bank and one glitch-free gate per output.
// Assumes an external open-drain pad turns sda_pull into a low on SDA.
module clkfan_cfg_slave
    import cfgbuf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull,
    input  logic               buf_clk,
    input  logic               drive_en,
    output logic [NUM_OUT-1:0] fan_clk,
    output logic [NUM_OUT-1:0] fan_drive
);
    logic               scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx, rd_idx;
    logic [7:0]         wr_data, rd_data;
    logic [REG_BYTES*8-1:0] cfg_flat;
    logic [NUM_OUT-1:0] en_vec;

    tw_line_sampler #(.SYNC_STAGES(2)) u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop)
    );

    tw_block_engine u_engine (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .bus_start(bus_start),
        .bus_stop(bus_stop), .sda_pull(sda_pull), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    cfg_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .cfg_flat(cfg_flat)
    );

    // Enable map: byte1[7:6] -> 9..8, byte2[7:4] -> 7..4, byte0[3:0] -> 3..0.
    assign en_vec = {cfg_flat[15:14], cfg_flat[23:20], cfg_flat[3:0]};

    // Global pad drive control, identical for every output.
    assign fan_drive = {NUM_OUT{drive_en}};

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
        clk_gate_lane #(.SYNC_STAGES(2)) u_lane (
            .sys_clk(clk), .rst_n(rst_n), .buf_clk(buf_clk),
            .en_req(en_vec[g]), .gated(fan_clk[g])
        );
    end
endmodule

// File: tb/test_clkfan_cfg_slave.sv
`timescale 1ns/1ps
module test_clkfan_cfg_slave;
    localparam int Q = 10;   // system clocks per quarter SCL period

    logic       clk = 1'b0, rst_n = 1'b0, buf_clk = 1'b0, drive_en = 1'b1;
    logic       scl_h = 1'b1, sda_h = 1'b1;
    logic       sda_pull;
    logic [9:0] fan_clk, fan_drive;
    wire        sda_line = sda_h & ~sda_pull;
    int         n_chk = 0, n_bad = 0, glitches = 0;
    logic       last_ack;
    logic [7:0] last_byte;

    clkfan_cfg_slave i_clkfan_cfg_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_h), .sda_in(sda_line),
        .sda_pull(sda_pull), .buf_clk(buf_clk), .drive_en(drive_en),
        .fan_clk(fan_clk), .fan_drive(fan_drive)
    );

    always #5 clk = ~clk;
    always #14 buf_clk = ~buf_clk;

    // Pulse-width monitor for R10: every high pulse must last a full 14 ns phase.
    logic [9:0] prev_fc = '0;
    realtime    rise_t [10];
    always @(fan_clk) begin
        for (int i = 0; i < 10; i++) begin
            if (fan_clk[i] && !prev_fc[i]) rise_t[i] = $realtime;
            if (!fan_clk[i] && prev_fc[i] && ($realtime - rise_t[i]) < 13.5) glitches++;
        end
        prev_fc = fan_clk;
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic bus_start();
        sda_h = 1'b1; scl_h = 1'b1; wt(Q);
        sda_h = 1'b0; wt(Q);
        scl_h = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wt(Q);
        scl_h = 1'b1; wt(Q);
        sda_h = 1'b1; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; wt(Q);
            scl_h = 1'b1; wt(2*Q);
            scl_h = 1'b0; wt(Q);
        end
        sda_h = 1'b1; wt(Q);
        scl_h = 1'b1; wt(Q);
        last_ack = !sda_line; wt(Q);
        scl_h = 1'b0; wt(Q);
    endtask

    task automatic recv_byte(input logic ack_it);
        sda_h = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(Q);
            scl_h = 1'b1; wt(Q);
            last_byte[i] = sda_line; wt(Q);
            scl_h = 1'b0; wt(Q);
        end
        sda_h = !ack_it; wt(Q);
        scl_h = 1'b1; wt(2*Q);
        scl_h = 1'b0; wt(Q);
        sda_h = 1'b1;
    endtask

    // Block write: address, command, length, then n data bytes.
    task automatic do_write(input int n, input logic [7:0] b0, b1, b2, b3, b4, b5,
                            input string req);
        logic [7:0] d [6];
        d = '{b0, b1, b2, b3, b4, b5};
        bus_start();
        send_byte(8'hD2);
        chk(last_ack, "R1", "write address ack", last_ack, 1);
        send_byte(8'h5A);
        chk(last_ack, "R2", "command ack", last_ack, 1);
        send_byte(8'h00);
        chk(last_ack, "R2", "length ack", last_ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i]);
            chk(last_ack, (i > 2) ? "R11" : req, "data ack", last_ack, 1);
        end
        bus_stop();
        #200;
    endtask

    // Block read: expect length 7, bytes 0..2 given, bytes 3..6 FFh.
    task automatic do_read(input logic [7:0] e0, e1, e2, input string req);
        logic [7:0] e [7];
        e = '{e0, e1, e2, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        bus_start();
        send_byte(8'hD3);
        chk(last_ack, "R1", "read address ack", last_ack, 1);
        recv_byte(1'b1);
        chk(last_byte == 8'd7, "R5", "length byte", last_byte, 7);
        for (int i = 0; i < 7; i++) begin
            recv_byte(i != 6);
            chk(last_byte == e[i], (i > 2) ? "R5" : req, "read byte", last_byte, e[i]);
        end
        bus_stop();
    endtask

    // Sample all outputs across more than one buffer period; record which ran.
    task automatic check_run(input logic [9:0] mask, input string req);
        logic [9:0] seen = '0;
        #150;
        for (int i = 0; i < 24; i++) begin
            #1.3;
            seen |= fan_clk;
        end
        chk(seen == mask, req, "running outputs", seen, mask);
    endtask

    task automatic t_reset();
        chk(fan_drive == 10'h3FF, "R8", "drive after reset", fan_drive, 10'h3FF);
        chk(sda_pull == 1'b0, "R8", "sda released", sda_pull, 0);
        check_run(10'h3FF, "R8");
        do_read(8'hFF, 8'hFF, 8'hFF, "R8");
    endtask

    task automatic t_bad_addr();
        bus_start();
        send_byte(8'hA0);
        chk(!last_ack, "R1", "foreign address nack", last_ack, 0);
        send_byte(8'h00);
        chk(!last_ack, "R1", "ignored byte nack", last_ack, 0);
        bus_stop();
        check_run(10'h3FF, "R1");
    endtask

    task automatic t_write_basic();
        do_write(3, 8'h05, 8'h40, 8'hA0, 8'h00, 8'h00, 8'h00, "R3");
        check_run(10'h1A5, "R6");
        do_read(8'h05, 8'h40, 8'hA0, "R3");
    endtask

    task automatic t_partial();
        do_write(1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R4");
        do_read(8'hFF, 8'h40, 8'hA0, "R4");
        check_run(10'h1AF, "R4");
    endtask

    task automatic t_extra();
        do_write(6, 8'h0F, 8'hC0, 8'hF0, 8'h12, 8'h34, 8'h56, "R11");
        do_read(8'h0F, 8'hC0, 8'hF0, "R11");
        check_run(10'h3FF, "R11");
    endtask

    task automatic t_map();
        do_write(3, 8'hF0, 8'h3F, 8'h1F, 8'h00, 8'h00, 8'h00, "R7");
        check_run(10'h010, "R7");
        do_read(8'hF0, 8'h3F, 8'h1F, "R7");
    endtask

    task automatic t_drive();
        drive_en = 1'b0; #20;
        chk(fan_drive == 10'h000, "R9", "drive off", fan_drive, 0);
        #200;
        drive_en = 1'b1; #20;
        chk(fan_drive == 10'h3FF, "R9", "drive on", fan_drive, 10'h3FF);
        check_run(10'h010, "R9");
    endtask

    initial begin
        #1_900_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wt(5);
        rst_n = 1'b1;
        wt(5);
        t_reset();
        t_bad_addr();
        t_write_basic();
        t_partial();
        t_extra();
        t_map();
        t_drive();
        chk(glitches == 0, "R10", "short output pulses", glitches, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule